// File: doc/BRIEF.md
# Linearly Interpolated Sine Oscillator

This block is a numerically controlled oscillator with a sine output. A phase accumulator advances by a frequency word on every clock. The upper phase bits select an entry of a sine table, and the bits just below them form a fraction within that table segment. A second table holds, for each segment, the difference between that entry and the next one. The fraction multiplied by this difference is added to the table sample. The output therefore traces a straight line between neighbouring table points and changes on every clock. At low output frequencies this gives a fine staircase instead of coarse steps that appear only when the table address moves on.

The output is a 12-bit two's-complement code for a DAC, with a flag that says the pipeline holds real data. Accuracy matters most near the zero crossings, where the slope is steepest and the interpolation carries the most weight. Downstream, the sample feeds a DAC, a low-pass filter and a comparator. None of these are part of this block.

Top module: `nco_lerp_sine`

## Requirements
- R1: While `rst_n` is low, `sample_o` is 0, `valid_o` is 0 and the phase is 0 (asynchronous clear).
- R2: A rising `rst_n` takes effect through a two-flop synchronizer. The core runs from the third rising edge after the release, so `valid_o` is first high after the fifth rising edge.
- R3: On every running edge the phase becomes phase + `freq_word`, modulo 2^PHASE_W.
- R4: The table address is phase bits [PHASE_W-1 : PHASE_W-ADDR_W]. The fraction is the FRAC_W bits directly below them. Lower bits are ignored.
- R5: Table entry a equals 2047·sin(2πa/2^ADDR_W), rounded to the nearest integer with ties away from zero.
- R6: Slope entry a equals table[a+1] − table[a]. For the last entry, the next entry is table[0].
- R7: The sample is table[a] + floor((slope[a]·frac + 2^(FRAC_W-1)) / 2^FRAC_W), clamped to the range −2048..2047.
- R8: A phase value present between two edges reaches `sample_o` after the third following edge. `valid_o` rises with the first such sample and stays high until reset.
- R9: A new interpolated sample is produced on every clock, including clocks on which the table address does not change.
- R10: With a zero frequency word, the output holds a constant value.
- R11: Phase wrap-around in either direction (a large word acting as a negative step) continues the waveform without a discontinuity beyond the interpolation rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | PHASE_W (32) | Phase increment per clock |
| sample_o | output | CODE_W (12) | Signed interpolated sine code |
| valid_o | output | 1 | High once the pipeline holds real samples |

## Verification
The bench builds the block with a 256-entry table (ADDR_W = 8), a 12-bit fraction and a 32-bit phase. With these values one full table sweep takes only a few hundred clocks, so every entry, including the wrapping last slope, is reached in a short run. A word of 2^16 keeps the address fixed for 256 clocks, which makes the per-clock interpolation directly visible. Negative-step and near-Nyquist words then exercise wrap-around and large fractional jumps against a behavioural model compared on every cycle.

// File: rtl/nco_lerp_pkg.sv
package nco_lerp_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded sine code for one table entry, ties away from zero
  function automatic int sine_code(input int idx, input int depth, input int amp);
    real r;
    r = real'(amp) * $sin(TWO_PI * real'(idx) / real'(depth));
    if (r >= 0.0) return $rtoi(r + 0.5);
    else          return -$rtoi(0.5 - r);
  endfunction

endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign core_rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic               adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    phase_d = phase_q;
    if (adv_en) phase_d = phase_q + step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
  parameter int ADDR_W  = 10,
  parameter int CODE_W  = 12,
  parameter int SLOPE_W = 13,
  parameter int AMP     = 2047
) (
  input  logic [ADDR_W-1:0]         addr_i,
  output logic signed [CODE_W-1:0]  base_o,
  output logic signed [SLOPE_W-1:0] slope_o
);
  import nco_lerp_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic signed [CODE_W-1:0]  base_tab  [DEPTH];
  logic signed [SLOPE_W-1:0] slope_tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int CUR = sine_code(i, DEPTH, AMP);
    localparam int NXT = sine_code((i + 1) % DEPTH, DEPTH, AMP);
    assign base_tab[i]  = CODE_W'(CUR);
    assign slope_tab[i] = SLOPE_W'(NXT - CUR);
  end

  assign base_o  = base_tab[addr_i];
  assign slope_o = slope_tab[addr_i];

endmodule

// File: rtl/nco_lerp_pipe.sv
module nco_lerp_pipe #(
  parameter int CODE_W  = 12,
  parameter int SLOPE_W = 13,
  parameter int FRAC_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [CODE_W-1:0]  base_i,
  input  logic signed [SLOPE_W-1:0] slope_i,
  input  logic [FRAC_W-1:0]         frac_i,
  output logic signed [CODE_W-1:0]  sample_o,
  output logic                      valid_o
);

  localparam int PROD_W = SLOPE_W + FRAC_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0]  SMAX = SUM_W'((1 << (CODE_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0]  SMIN = ~SMAX;

  // stage 1: table outputs and fraction
  logic signed [CODE_W-1:0]  base1_q;
  logic signed [SLOPE_W-1:0] slope1_q;
  logic [FRAC_W-1:0]         frac1_q;
  logic                      v1_q;
  // stage 2: product
  logic signed [CODE_W-1:0]  base2_q, base2_d;
  logic signed [PROD_W-1:0]  prod2_q, prod2_d;
  logic                      v2_q;
  // stage 3: rounded, clamped sample
  logic signed [CODE_W-1:0]  out_q, out_d;
  logic                      v3_q;

  logic                      en1, en2, en3;
  logic signed [PROD_W-1:0]  rnd;
  logic signed [SUM_W-1:0]   sum;

  assign en1 = 1'b1;
  assign en2 = v1_q;
  assign en3 = v2_q;

  always_comb begin
    base2_d = base1_q;
    prod2_d = PROD_W'(slope1_q) * PROD_W'($signed({1'b0, frac1_q}));
  end

  always_comb begin
    rnd = (prod2_q + HALF) >>> FRAC_W;
    sum = SUM_W'(base2_q) + SUM_W'(rnd);
    if (sum > SMAX)      out_d = CODE_W'(SMAX);
    else if (sum < SMIN) out_d = CODE_W'(SMIN);
    else                 out_d = CODE_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base1_q  <= '0;
      slope1_q <= '0;
      frac1_q  <= '0;
      v1_q     <= 1'b0;
    end else if (en1) begin
      base1_q  <= base_i;
      slope1_q <= slope_i;
      frac1_q  <= frac_i;
      v1_q     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base2_q <= '0;
      prod2_q <= '0;
      v2_q    <= 1'b0;
    end else if (en2) begin
      base2_q <= base2_d;
      prod2_q <= prod2_d;
      v2_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      v3_q  <= 1'b0;
    end else if (en3) begin
      out_q <= out_d;
      v3_q  <= 1'b1;
    end
  end

  assign sample_o = out_q;
  assign valid_o  = v3_q;

endmodule

// File: rtl/nco_lerp_sine.sv
module nco_lerp_sine #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 12,
  parameter int CODE_W  = 12,
  parameter int AMP     = 2047
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PHASE_W-1:0]       freq_word,
  output logic signed [CODE_W-1:0] sample_o,
  output logic                     valid_o
);

  localparam int SLOPE_W = CODE_W + 1;
  localparam int LSB_W   = PHASE_W - ADDR_W - FRAC_W;

  logic                      core_rst_n;
  logic [PHASE_W-1:0]        phase_q;
  logic [ADDR_W-1:0]         addr;
  logic [FRAC_W-1:0]         frac;
  logic signed [CODE_W-1:0]  base;
  logic signed [SLOPE_W-1:0] slope;

  nco_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n)
  );

  nco_phase_acc #(.PHASE_W(PHASE_W)) acc_i (
    .clk(clk), .rst_n(core_rst_n), .step_i(freq_word), .phase_o(phase_q)
  );

  assign addr = phase_q[PHASE_W-1 -: ADDR_W];
  assign frac = phase_q[PHASE_W-ADDR_W-1 -: FRAC_W];

  if (LSB_W > 0) begin : g_lsb
    logic unused_lsb;
    assign unused_lsb = ^phase_q[LSB_W-1:0];
  end

  nco_sine_rom #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .AMP(AMP)
  ) rom_i (
    .addr_i(addr), .base_o(base), .slope_o(slope)
  );

  nco_lerp_pipe #(
    .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W)
  ) pipe_i (
    .clk(clk), .rst_n(core_rst_n),
    .base_i(base), .slope_i(slope), .frac_i(frac),
    .sample_o(sample_o), .valid_o(valid_o)
  );

endmodule

// File: rtl/nco_lerp_sine_chk.sv
module nco_lerp_sine_chk #(
  parameter int PHASE_W = 32,
  parameter int CODE_W  = 12
) (
  input logic                     clk,
  input logic                     core_rst_n,
  input logic [PHASE_W-1:0]       phase,
  input logic [PHASE_W-1:0]       freq_word,
  input logic signed [CODE_W-1:0] sample_o,
  input logic                     valid_o
);

  logic [1:0]         fill_cnt;
  logic               ran_q;
  logic [PHASE_W-1:0] ph_prev;
  logic [2:0]         hold_cnt;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      fill_cnt <= '0;
      ran_q    <= 1'b0;
      ph_prev  <= '0;
      hold_cnt <= '0;
    end else begin
      if (fill_cnt != 2'd3) fill_cnt <= fill_cnt + 2'd1;
      ran_q   <= 1'b1;
      ph_prev <= phase;
      if (phase != ph_prev)     hold_cnt <= '0;
      else if (hold_cnt != 3'd7) hold_cnt <= hold_cnt + 3'd1;
    end
  end

  // R8
  fill_latency_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    valid_o == (fill_cnt == 2'd3));

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    valid_o |=> valid_o);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !valid_o |-> sample_o == '0);

  // R3
  acc_step_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ran_q |-> phase == $past(phase + freq_word));

  // R10
  frozen_phase_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (hold_cnt >= 3'd4 && valid_o && $past(valid_o)) |-> $stable(sample_o));

endmodule

bind nco_lerp_sine nco_lerp_sine_chk #(.PHASE_W(PHASE_W), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .core_rst_n(core_rst_n), .phase(phase_q),
  .freq_word(freq_word), .sample_o(sample_o), .valid_o(valid_o)
);

// File: tb/nco_lerp_sine_tb_top.sv
module nco_lerp_sine_tb_top;

  localparam int  PW  = 32;
  localparam int  AW  = 8;
  localparam int  FW  = 12;
  localparam int  N   = 1 << AW;
  localparam real PI2 = 2.0 * 3.14159265358979323846;

  logic              clk;
  logic              rst_n;
  logic [PW-1:0]     freq_word;
  logic signed [11:0] sample_o;
  logic              valid_o;

  int    n_chk, n_err;
  string cur_req;

  nco_lerp_sine #(.PHASE_W(PW), .ADDR_W(AW), .FRAC_W(FW), .CODE_W(12), .AMP(2047)) dut_i (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .sample_o(sample_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic int tab(input int a);
    real r;
    r = 2047.0 * $sin(PI2 * real'(a) / real'(N));
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(0.5 - r);
  endfunction

  function automatic int model_sample(input logic [PW-1:0] ph);
    int a, f, b, s, y;
    longint p;
    a = int'(ph >> (PW - AW));
    f = int'((ph >> (PW - AW - FW)) & ((1 << FW) - 1));
    b = tab(a);
    s = tab((a + 1) % N) - b;
    p = longint'(s) * longint'(f) + longint'(1 << (FW - 1));
    y = b + int'(p >>> FW);
    if (y > 2047)  y = 2047;
    if (y < -2048) y = -2048;
    return y;
  endfunction

  int            q[$];
  logic          m_rs0, m_rs1, m_run;
  logic [PW-1:0] m_acc;
  int            exp_s;
  logic          exp_v;

  initial begin
    m_rs0 = 0; m_rs1 = 0; m_acc = '0; exp_s = 0; exp_v = 0;
  end

  always @(posedge clk) begin
    m_run = m_rs1;
    if (!rst_n) begin
      m_rs0 = 0; m_rs1 = 0; m_acc = '0; q.delete(); exp_s = 0; exp_v = 0;
    end else begin
      m_rs1 = m_rs0;
      m_rs0 = 1;
      if (m_run) begin
        q.push_back(model_sample(m_acc));
        m_acc = m_acc + freq_word;
        if (q.size() > 2) begin
          exp_s = q.pop_front();
          exp_v = 1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    n_chk++;
    if (!rst_n) begin
      if (sample_o !== 12'sd0 || valid_o !== 1'b0) begin
        n_err++;
        $display("FAIL R1: sample=%0d valid=%0b expected sample=0 valid=0", sample_o, valid_o);
      end
    end else if (int'(sample_o) != exp_s || valid_o !== exp_v) begin
      n_err++;
      $display("FAIL %s: sample=%0d valid=%0b expected sample=%0d valid=%0b",
               cur_req, sample_o, valid_o, exp_s, exp_v);
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [PW-1:0] fw);
    int first;
    first = 0;
    @(negedge clk);
    rst_n = 1'b0;
    freq_word = fw;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset sample", int'(sample_o), 0);
    chk("R1 reset valid", int'(valid_o), 0);
    rst_n = 1'b1;
    cur_req = "R8";
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      #2;
      if (valid_o && first == 0) first = i;
    end
    chk("R2 edges to first valid", first, 5);
  endtask

  task automatic run(input string req, input logic [PW-1:0] fw, input int cycles);
    @(negedge clk);
    cur_req = req;
    freq_word = fw;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    int changes;
    int prev;
    int hold_v;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0;
    freq_word = '0;
    cur_req = "R1";

    // R5: one table entry per clock, zero fraction
    do_reset(32'h0100_0000);
    run("R5", 32'h0100_0000, 300);

    // R9: address held for 256 clocks, output must still move
    do_reset(32'h0001_0000);
    cur_req = "R9";
    changes = 0;
    prev = int'(sample_o);
    for (int i = 0; i < 190; i++) begin
      @(negedge clk);
      #2;
      if (int'(sample_o) != prev) changes++;
      prev = int'(sample_o);
    end
    chk("R9 per-clock updates within one segment (>=30)", (changes >= 30) ? 1 : 0, 1);

    // R4/R7: arbitrary word exercising all fraction bits
    run("R4 R7", 32'h0123_4567, 500);

    // R6/R11: negative step from phase 0 enters the last entry and wraps
    do_reset(32'hFFFF_F000);
    run("R6 R11", 32'hFFFF_F000, 300);
    run("R11", 32'hFF00_0800, 400);

    // R10: zero word holds the output
    run("R10", 32'h0, 6);
    #2;
    hold_v = int'(sample_o);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #2;
      chk("R10 output held", int'(sample_o), hold_v);
    end

    // R7: near-Nyquist word
    run("R7", 32'h7FFF_FFFF, 100);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule